// File: doc/BRIEF.md
# Oversampled Time-Delay-Integration Summing Engine

This block adds up digitized samples from a row of eight detector pixels that a moving scene sweeps across one after another. Every scene point passes each pixel in turn, and the scan is oversampled three times per pixel pitch. The block keeps a staggered set of partial sums, one per sub-sample slot in flight. Each pixel's sample is added to the partial sum that belongs to the scene point over that pixel at that moment. Once a scene point has crossed all eight pixels, its finished total leaves the block.

Each pixel sample arrives as a coarse count and a fine residual. The scan can run in either direction, which reverses the order in which pixels feed a sum. Any pixel can be switched off. A finished sum is then rescaled so that it keeps the level of a full eight-pixel sum. Finished 16-bit words are sent out one bit per clock, most significant bit first, and a marker flags the first bit of each word.

Top module: `tdi_accum`

## Requirements
- R1: A sub-sample strobe (`sampleStrobe` high for one clock) advances the scan. The scene point that starts at strobe j is the sum of eight samples. The sample taken from the pixel in scan position k comes from strobe j+3k, for k = 0..7.
- R2: The value of pixel p is coarse*256 + fine. The coarse part is lane p of `coarseIn`, bits [5p+4:5p], 5 bits wide. The fine part is lane p of `fineIn`, bits [8p+7:8p], 8 bits wide. Pixel p is enabled by bit p of `pixelEnable`.
- R3: The first finished word comes from the 22nd strobe after reset or after a direction flush. After that, each further strobe finishes exactly one word.
- R4: With `scanReverse` = 0, scan position k is pixel k. With `scanReverse` = 1, scan position k is pixel 7-k.
- R5: A change of `scanReverse` clears every partial sum and restarts the fill count. A strobe in the same clock as the change is ignored. No finished word mixes samples from both directions.
- R6: A disabled pixel adds 0. With n pixels enabled, the raw sum is multiplied by round(2048/n) and then shifted right by 8. The multipliers are 2048, 1024, 683, 512, 410, 341, 293 and 256.
- R7: A rescaled value above 65535 is output as 65535.
- R8: With no pixel enabled, every word is 0. `noPixels` is high from the clock after `pixelEnable` becomes all zeros.
- R9: A word is sent on `serialOut` as 16 consecutive bits, most significant bit first. `wordStart` is high only while bit 15 is shown.
- R10: A new word is loaded only once all 16 bits of the previous word have been shown. A word that finishes while a word is still being sent is discarded.
- R11: While reset is held, `serialOut`, `wordStart` and `noPixels` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sampleStrobe | input | 1 | One-clock pulse per sub-sample period |
| scanReverse | input | 1 | Scan direction select |
| pixelEnable | input | 8 | Per-pixel enable mask |
| coarseIn | input | 40 | Coarse count of each pixel, 5 bits per lane |
| fineIn | input | 64 | Fine residual of each pixel, 8 bits per lane |
| serialOut | output | 1 | Serial result bit |
| wordStart | output | 1 | High with the first bit of each word |
| noPixels | output | 1 | High when every pixel is disabled |

## Verification
A direction flush and a sub-sample strobe can land in the same clock. When they do, the flush must win and the strobe must be dropped. The bench provokes this by flipping `scanReverse` in the very clock that carries a strobe loaded with junk samples. It then judges the words that follow against scene points counted from the next strobe only. A single slipped strobe would shift every later scene point and change each expected word. The other collision, a word that finishes while the serializer is busy, is driven with strobes eight clocks apart. The bench then expects exactly every other word to come out.

// File: rtl/tdi_pkg.sv
package tdi_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic shift;    // advance the partial-sum chain
    logic flush;    // clear every partial sum
    logic done;     // last stage holds a finished sum
    logic load;     // move the scaled word into the serializer
    logic reverse;  // active scan direction
  } tdiCtl_t;

endpackage

// File: rtl/tdi_ctrl.sv
module tdi_ctrl
  import tdi_pkg::*;
#(
  parameter int NPIX       = 8,
  parameter int OVERSAMPLE = 3,
  parameter int OUT_W      = 16
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    sampleStrobe,
  input  logic    scanReverse,
  output tdiCtl_t ctl,
  output logic    wordStart
);

  localparam int DEPTH  = OVERSAMPLE * (NPIX - 1) + 1;
  localparam int FILL_W = $clog2(DEPTH + 1);
  localparam int BIT_W  = $clog2(OUT_W);

  logic              activeDir;
  logic [FILL_W-1:0] fillCnt;
  logic              doneQ;
  logic              scaledValid;
  logic [BIT_W-1:0]  remCnt;
  logic              wordStartQ;

  logic flushC, shiftC, loadC;

  assign flushC = (scanReverse != activeDir);
  assign shiftC = sampleStrobe && !flushC;
  assign loadC  = scaledValid && (remCnt == '0);

  assign ctl.shift   = shiftC;
  assign ctl.flush   = flushC;
  assign ctl.done    = doneQ;
  assign ctl.load    = loadC;
  assign ctl.reverse = activeDir;
  assign wordStart   = wordStartQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      activeDir   <= 1'b0;
      fillCnt     <= '0;
      doneQ       <= 1'b0;
      scaledValid <= 1'b0;
      remCnt      <= '0;
      wordStartQ  <= 1'b0;
    end else begin
      activeDir <= scanReverse;
      if (flushC) begin
        fillCnt <= '0;
      end else if (shiftC && (fillCnt != FILL_W'(DEPTH))) begin
        fillCnt <= fillCnt + 1'b1;
      end
      doneQ       <= shiftC && (fillCnt >= FILL_W'(DEPTH - 1));
      scaledValid <= doneQ;
      if (loadC) begin
        remCnt <= BIT_W'(OUT_W - 1);
      end else if (remCnt != '0) begin
        remCnt <= remCnt - 1'b1;
      end
      wordStartQ <= loadC;
    end
  end

endmodule

// File: rtl/tdi_datapath.sv
module tdi_datapath
  import tdi_pkg::*;
#(
  parameter int NPIX       = 8,
  parameter int OVERSAMPLE = 3,
  parameter int COARSE_W   = 5,
  parameter int FINE_W     = 8,
  parameter int OUT_W      = 16,
  parameter int FRAC_W     = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  tdiCtl_t                  ctl,
  input  logic [NPIX-1:0]          pixelEnable,
  input  logic [NPIX*COARSE_W-1:0] coarseIn,
  input  logic [NPIX*FINE_W-1:0]   fineIn,
  output logic                     serialOut,
  output logic                     noPixels,
  output logic [OUT_W-1:0]         lastSum
);

  localparam int DEPTH  = OVERSAMPLE * (NPIX - 1) + 1;
  localparam int CNT_W  = $clog2(NPIX + 1);
  localparam int MULT_W = FRAC_W + $clog2(NPIX) + 1;
  localparam int PROD_W = OUT_W + MULT_W;

  // Rounded fixed-point value of NPIX/n
  function automatic logic [MULT_W-1:0] gainMult(input int n);
    int num;
    num = NPIX << (FRAC_W + 1);
    if (n == 0) return '0;
    return MULT_W'((num / n + 1) / 2);
  endfunction

  logic [MULT_W-1:0] multTab [NPIX+1];
  for (genvar g = 0; g <= NPIX; g++) begin : g_mult
    assign multTab[g] = gainMult(g);
  end

  // Per-lane values with enables applied, then reordered by scan direction
  logic [OUT_W-1:0] laneVal  [NPIX];
  logic [OUT_W-1:0] orderVal [NPIX];
  for (genvar p = 0; p < NPIX; p++) begin : g_lane
    assign laneVal[p] = pixelEnable[p]
      ? OUT_W'({coarseIn[p*COARSE_W +: COARSE_W], fineIn[p*FINE_W +: FINE_W]})
      : '0;
    assign orderVal[p] = ctl.reverse ? laneVal[NPIX-1-p] : laneVal[p];
  end

  // Staggered partial sums: a pixel taps in every OVERSAMPLE stages
  logic [OUT_W-1:0] psum [DEPTH];
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [OUT_W-1:0] prevVal, addVal, stageQ;
    if (i == 0) begin : g_head
      assign prevVal = '0;
    end else begin : g_link
      assign prevVal = psum[i-1];
    end
    if (i % OVERSAMPLE == 0) begin : g_tap
      assign addVal = orderVal[i / OVERSAMPLE];
    end else begin : g_gap
      assign addVal = '0;
    end
    always_ff @(posedge clk) begin
      if (rst || ctl.flush) begin
        stageQ <= '0;
      end else if (ctl.shift) begin
        stageQ <= prevVal + addVal;
      end
    end
    assign psum[i] = stageQ;
  end

  assign lastSum = psum[DEPTH-1];

  // Gain compensation and saturation
  logic [CNT_W-1:0]  enCount;
  logic [PROD_W-1:0] prod, prodShift;
  logic [OUT_W-1:0]  satWord, scaledWord;

  assign enCount   = CNT_W'($countones(pixelEnable));
  assign prod      = PROD_W'(lastSum) * PROD_W'(multTab[enCount]);
  assign prodShift = prod >> FRAC_W;
  assign satWord   = (|prodShift[PROD_W-1:OUT_W]) ? '1 : prodShift[OUT_W-1:0];

  logic [OUT_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      scaledWord <= '0;
      shiftReg   <= '0;
      noPixels   <= 1'b0;
    end else begin
      if (ctl.done) scaledWord <= satWord;
      if (ctl.load) shiftReg <= scaledWord;
      else          shiftReg <= {shiftReg[OUT_W-2:0], 1'b0};
      noPixels <= (pixelEnable == '0);
    end
  end

  assign serialOut = shiftReg[OUT_W-1];

endmodule

// File: rtl/tdi_accum.sv
module tdi_accum
  import tdi_pkg::*;
#(
  parameter int NPIX       = 8,
  parameter int OVERSAMPLE = 3,
  parameter int COARSE_W   = 5,
  parameter int FINE_W     = 8,
  parameter int OUT_W      = 16,
  parameter int FRAC_W     = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sampleStrobe,
  input  logic                     scanReverse,
  input  logic [NPIX-1:0]          pixelEnable,
  input  logic [NPIX*COARSE_W-1:0] coarseIn,
  input  logic [NPIX*FINE_W-1:0]   fineIn,
  output logic                     serialOut,
  output logic                     wordStart,
  output logic                     noPixels
);

  tdiCtl_t          ctl;
  logic [OUT_W-1:0] lastSum;

  tdi_ctrl #(
    .NPIX(NPIX), .OVERSAMPLE(OVERSAMPLE), .OUT_W(OUT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .sampleStrobe(sampleStrobe),
    .scanReverse(scanReverse), .ctl(ctl), .wordStart(wordStart)
  );

  tdi_datapath #(
    .NPIX(NPIX), .OVERSAMPLE(OVERSAMPLE), .COARSE_W(COARSE_W),
    .FINE_W(FINE_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .pixelEnable(pixelEnable),
    .coarseIn(coarseIn), .fineIn(fineIn), .serialOut(serialOut),
    .noPixels(noPixels), .lastSum(lastSum)
  );

endmodule

// File: rtl/tdi_accum_chk.sv
module tdi_accum_chk
  import tdi_pkg::*;
#(
  parameter int NPIX  = 8,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input tdiCtl_t          ctl,
  input logic [OUT_W-1:0] lastSum,
  input logic [NPIX-1:0]  pixelEnable,
  input logic             noPixels,
  input logic             wordStart
);

  localparam int GAP_W = $clog2(OUT_W + 1);
  logic [GAP_W-1:0] sinceStart;

  always_ff @(posedge clk) begin
    if (rst)                                sinceStart <= GAP_W'(OUT_W);
    else if (wordStart)                     sinceStart <= GAP_W'(1);
    else if (sinceStart < GAP_W'(OUT_W))    sinceStart <= sinceStart + 1'b1;
  end

  assert_word_spacing_R10: assert property (@(posedge clk) disable iff (rst)
    wordStart |-> (sinceStart >= GAP_W'(OUT_W)));

  assert_no_pixels_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (pixelEnable == '0) |=> noPixels);

  assert_flush_clears_R5: assert property (@(posedge clk) disable iff (rst)
    ctl.flush |=> (lastSum == '0));

  assert_done_after_shift_R3: assert property (@(posedge clk) disable iff (rst)
    ctl.done |-> $past(ctl.shift));

endmodule

bind tdi_accum tdi_accum_chk #(.NPIX(NPIX), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .ctl(ctl), .lastSum(lastSum),
  .pixelEnable(pixelEnable), .noPixels(noPixels), .wordStart(wordStart)
);

// File: tb/tdi_accum_test.sv
module tdi_accum_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sampleStrobe = 1'b0;
  logic        scanReverse = 1'b0;
  logic [7:0]  pixelEnable = 8'hFF;
  logic [39:0] coarseIn = '0;
  logic [63:0] fineIn = '0;
  logic        serialOut, wordStart, noPixels;

  int errors = 0;
  int checks = 0;
  int patMode = 0;
  bit finished = 0;

  logic [15:0] rxWords [64];
  int          rxCnt = 0;
  int          rxLeft = 0;
  logic [15:0] rxAcc;

  always #5 clk = ~clk;

  tdi_accum uut (
    .clk(clk), .rst(rst), .sampleStrobe(sampleStrobe), .scanReverse(scanReverse),
    .pixelEnable(pixelEnable), .coarseIn(coarseIn), .fineIn(fineIn),
    .serialOut(serialOut), .wordStart(wordStart), .noPixels(noPixels)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Serial collector (R9)
  always @(negedge clk) begin
    if (rst) begin
      rxCnt  = 0;
      rxLeft = 0;
    end else if (rxLeft > 0) begin
      if (wordStart) check(1'b0, "R9 wordStart inside word", 1, 0);
      rxAcc  = {rxAcc[14:0], serialOut};
      rxLeft = rxLeft - 1;
      if (rxLeft == 0) begin
        if (rxCnt < 64) rxWords[rxCnt] = rxAcc;
        rxCnt = rxCnt + 1;
      end
    end else if (wordStart) begin
      rxAcc  = {15'b0, serialOut};
      rxLeft = 15;
    end
  end

  function automatic int val(input int idx, input int p);
    if (patMode == 1) return 8191;
    return (idx * 37 + p * 101 + 5) & 8191;
  endfunction

  function automatic int expWord(input int j, input int base, input bit rev, input logic [7:0] mask);
    int sum = 0;
    int n;
    longint r;
    for (int k = 0; k < 8; k++) begin
      int pix = rev ? 7 - k : k;
      if (mask[pix]) sum += val(base + j + 3 * k, pix);
    end
    n = $countones(mask);
    if (n == 0) return 0;
    r = (longint'(sum) * ((4096 / n + 1) / 2)) >>> 8;
    return (r > 65535) ? 65535 : int'(r);
  endfunction

  task automatic doReset(input bit rev, input logic [7:0] mask);
    @(negedge clk);
    rst = 1'b1;
    scanReverse = rev;
    pixelEnable = mask;
    sampleStrobe = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic driveLanes(input int idx);
    for (int p = 0; p < 8; p++) begin
      int v = val(idx, p);
      coarseIn[p*5 +: 5] = 5'(v >> 8);
      fineIn[p*8 +: 8]   = 8'(v);
    end
  endtask

  task automatic doStrobe(input int idx, input int period);
    driveLanes(idx);
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
    repeat (period - 1) @(negedge clk);
  endtask

  task automatic runAndCheck(input string tag, input int nStb, input int base,
                             input bit rev, input logic [7:0] mask);
    doReset(rev, mask);
    for (int s = 0; s < nStb; s++) doStrobe(base + s, 20);
    repeat (40) @(negedge clk);
    check(rxCnt == nStb - 21, {tag, " word count"}, rxCnt, nStb - 21);
    for (int j = 0; j < nStb - 21 && j < rxCnt; j++) begin
      int e = expWord(j, base, rev, mask);
      check(rxWords[j] == 16'(e), {tag, " word value"}, rxWords[j], e);
    end
  endtask

  task automatic testReset();  // R11, R3
    @(negedge clk);
    rst = 1'b1;
    pixelEnable = 8'hFF;
    repeat (2) @(negedge clk);
    check(serialOut == 1'b0, "R11 serialOut in reset", serialOut, 0);
    check(wordStart == 1'b0, "R11 wordStart in reset", wordStart, 0);
    check(noPixels == 1'b0, "R11 noPixels in reset", noPixels, 0);
    doReset(1'b0, 8'hFF);
    for (int s = 0; s < 21; s++) doStrobe(s, 10);
    repeat (30) @(negedge clk);
    check(rxCnt == 0, "R3 no word before 22 strobes", rxCnt, 0);
  endtask

  task automatic testForward();  // R1 R2 R3 R9
    patMode = 0;
    runAndCheck("R1 forward", 27, 0, 1'b0, 8'hFF);
  endtask

  task automatic testReverse();  // R4
    patMode = 0;
    runAndCheck("R4 reverse", 26, 50, 1'b1, 8'hFF);
  endtask

  task automatic testMask();  // R6
    patMode = 0;
    runAndCheck("R6 three enabled", 25, 7, 1'b0, 8'b0100_0101);
    runAndCheck("R6 four enabled", 24, 90, 1'b1, 8'b1011_0010);
  endtask

  task automatic testSaturate();  // R7
    patMode = 1;
    runAndCheck("R7 saturate", 24, 0, 1'b0, 8'b0001_0011);
    if (rxCnt > 0) check(rxWords[0] == 16'hFFFF, "R7 max word", rxWords[0], 65535);
    patMode = 0;
  endtask

  task automatic testNone();  // R8
    patMode = 0;
    runAndCheck("R8 none enabled", 24, 3, 1'b0, 8'h00);
    check(noPixels == 1'b1, "R8 noPixels flag", noPixels, 1);
    pixelEnable = 8'h01;
    @(negedge clk);
    check(noPixels == 1'b0, "R8 flag clears", noPixels, 0);
  endtask

  task automatic testDirChange();  // R5
    patMode = 0;
    doReset(1'b0, 8'hFF);
    for (int s = 0; s < 24; s++) doStrobe(s, 20);
    // Direction change and a junk strobe in the same clock
    driveLanes(999);
    scanReverse = 1'b1;
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
    repeat (19) @(negedge clk);
    for (int s = 0; s < 24; s++) doStrobe(300 + s, 20);
    repeat (40) @(negedge clk);
    check(rxCnt == 6, "R5 word count across flush", rxCnt, 6);
    for (int j = 0; j < 3; j++) begin
      int e0 = expWord(j, 0, 1'b0, 8'hFF);
      int e1 = expWord(j, 300, 1'b1, 8'hFF);
      check(rxWords[j] == 16'(e0), "R5 before flush", rxWords[j], e0);
      check(rxWords[j+3] == 16'(e1), "R5 after flush", rxWords[j+3], e1);
    end
  endtask

  task automatic testFast();  // R10
    patMode = 0;
    doReset(1'b0, 8'hFF);
    for (int s = 0; s < 40; s++) doStrobe(s, 8);
    repeat (60) @(negedge clk);
    check(rxCnt == 10, "R10 every other word kept", rxCnt, 10);
    for (int i = 0; i < 10 && i < rxCnt; i++) begin
      int e = expWord(2 * i, 0, 1'b0, 8'hFF);
      check(rxWords[i] == 16'(e), "R10 kept word intact", rxWords[i], e);
    end
  endtask

  initial begin
    testReset();
    testForward();
    testReverse();
    testMask();
    testSaturate();
    testNone();
    testDirChange();
    testFast();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule